// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns a stream of frame bytes, gathered from one or more consecutive transmit buffers, into a complete Ethernet frame on a byte-wide valid/ready output. The caller sends the bytes in order and marks the final byte of the packet with an end-of-packet flag. On that same byte it also gives a per-packet flag that asks for a frame check sequence. Buffer boundaries inside a packet are not visible here. The stream simply continues until the end-of-packet byte arrives.

The first fourteen bytes (destination address, source address, type/length) and all later payload bytes are forwarded unchanged. After the last input byte, the block can add zero pad bytes so that a short frame reaches the Ethernet minimum. It can then append the CRC-32 frame check sequence. A frame longer than the configured size limit is cut at the limit and flagged. The rest of that input packet is discarded. The output stage honours backpressure and never loses a byte.

Top module: `tx_frame_builder`

## Requirements
- R1: After reset, `out_valid` and `err_oversize` are low.
- R2: Every accepted input byte of a frame within the size limit leaves on the output unchanged and in order, including the 14 header bytes.
- R3: When `in_fcs` is high on the end-of-packet byte, four check bytes follow the data (and any pad). They hold the CRC-32 with polynomial 0x04C11DB7, reflected, initial value all ones and final inversion, computed over every data and pad byte of the frame, and they are sent least significant byte first.
- R4: `in_fcs` is ignored on any byte whose `in_eop` is low. Only the end-of-packet byte decides whether check bytes are appended.
- R5: With `cfg_pad_en` high, a frame of fewer than 60 data bytes is extended with 0x00 bytes to exactly 60 data bytes, which gives 64 bytes once the check sequence is added. Frames of 60 or more data bytes get no pad.
- R6: With `cfg_pad_en` low, a short frame is sent with no pad bytes.
- R7: A frame whose input exceeds the data limit (1532 bytes, or 9014 with `cfg_jumbo_en`) is output as exactly the first limit bytes, with `out_last` on the final one and no check sequence. `err_oversize` is high for one cycle, in the first cycle that final byte is presented. The remaining input up to and including its end-of-packet byte is accepted and discarded, and the next frame is handled normally.
- R8: A frame of exactly 1532 data bytes with `in_fcs` set is sent whole as 1536 bytes, and no error is flagged.
- R9: With `cfg_jumbo_en` high, frames longer than 1532 data bytes pass whole, with their check sequence.
- R10: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` hold. No byte is dropped or duplicated.
- R11: `out_last` is high on the final output byte of each frame and low on every other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pad_en | input | 1 | Pad short frames to the minimum length |
| cfg_jumbo_en | input | 1 | Raise the size limit to the jumbo value |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input frame byte |
| in_eop | input | 1 | Marks the last byte of the packet |
| in_fcs | input | 1 | Append check sequence (sampled on end-of-packet byte only) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final byte of the output frame |
| err_oversize | output | 1 | One-cycle pulse on a truncated frame |

## Verification
Frames are sent at lengths below, at and just around the 60-byte pad boundary, with padding both on and off and the check-sequence flag both on and off. This separates missing or extra pad bytes from a wrong CRC span. A frame that raises the check flag only on non-final bytes shows whether the flag is sampled at the wrong time. Frames at exactly the limit, above the limit, and above it with jumbo enabled separate an off-by-one in the limit from a wrong truncation or resumption. The same traffic is repeated with a periodic and a pseudo-random `out_ready` and with gaps in `in_valid`, which exposes lost, repeated or changed bytes under stall.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2,
        ST_DROP = 2'd3
    } txf_state_e;

    typedef struct packed {
        txf_state_e  state;
        logic        ov;
        logic [7:0]  od;
        logic        ol;
        logic        err;
        logic        fcs_sel;
        logic [1:0]  idx;
    } txf_ctl_t;

    // Reflected CRC-32 advance by one byte, LSB of the byte first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/txf_crc32.sv
module txf_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        advance,
    input  logic [7:0]  data,
    output logic [31:0] crc_q
);
    import txf_pkg::*;

    logic [31:0] crc_d;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = 32'hFFFF_FFFF;
        end else if (advance) begin
            crc_d = crc32_step(crc_q, data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= 32'hFFFF_FFFF;
        end else begin
            crc_q <= crc_d;
        end
    end
endmodule

// File: rtl/txf_len_ctr.sv
module txf_len_ctr #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tx_frame_builder.sv
module tx_frame_builder #(
    parameter int MIN_TOTAL   = 64,
    parameter int MAX_TOTAL   = 1536,
    parameter int JUMBO_TOTAL = 9018
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_pad_en,
    input  logic       cfg_jumbo_en,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_eop,
    input  logic       in_fcs,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       err_oversize
);
    import txf_pkg::*;

    localparam int FCS_BYTES  = 4;
    localparam int PAD_DATA   = MIN_TOTAL - FCS_BYTES;
    localparam int STD_DATA   = MAX_TOTAL - FCS_BYTES;
    localparam int JUMBO_DATA = JUMBO_TOTAL - FCS_BYTES;
    localparam int CNT_W      = $clog2(JUMBO_TOTAL + 1);

    txf_ctl_t         q, d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] limit;
    logic [31:0]      crc_q;
    logic [31:0]      crc_out;
    logic             slot_free;
    logic             ctr_inc, ctr_clr;
    logic             crc_adv, crc_clr;
    logic [7:0]       crc_byte;

    txf_len_ctr #(.CNT_W(CNT_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctr_clr),
        .inc   (ctr_inc),
        .cnt_q (cnt_q)
    );

    txf_crc32 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clr),
        .advance (crc_adv),
        .data    (crc_byte),
        .crc_q   (crc_q)
    );

    always_comb begin
        slot_free = !q.ov || out_ready;
        cnt_next  = cnt_q + CNT_W'(1);
        limit     = cfg_jumbo_en ? CNT_W'(JUMBO_DATA) : CNT_W'(STD_DATA);
        crc_out   = ~crc_q;
        in_ready  = ((q.state == ST_DATA) && slot_free) || (q.state == ST_DROP);
        crc_byte  = (q.state == ST_PAD) ? 8'h00 : in_data;

        d       = q;
        d.err   = 1'b0;
        ctr_inc = 1'b0;
        ctr_clr = 1'b0;
        crc_adv = 1'b0;
        crc_clr = 1'b0;
        if (slot_free) begin
            d.ov = 1'b0;
        end

        case (q.state)
            ST_DATA: begin
                if (in_valid && slot_free) begin
                    d.ov    = 1'b1;
                    d.od    = in_data;
                    d.ol    = 1'b0;
                    ctr_inc = 1'b1;
                    crc_adv = 1'b1;
                    if (in_eop) begin
                        if (cfg_pad_en && (cnt_next < CNT_W'(PAD_DATA))) begin
                            d.state   = ST_PAD;
                            d.fcs_sel = in_fcs;
                        end else if (in_fcs) begin
                            d.state = ST_FCS;
                            d.idx   = 2'd0;
                        end else begin
                            d.ol    = 1'b1;
                            ctr_clr = 1'b1;
                            crc_clr = 1'b1;
                        end
                    end else if (cnt_next == limit) begin
                        d.ol    = 1'b1;
                        d.err   = 1'b1;
                        d.state = ST_DROP;
                        ctr_clr = 1'b1;
                        crc_clr = 1'b1;
                    end
                end
            end
            ST_PAD: begin
                if (slot_free) begin
                    d.ov    = 1'b1;
                    d.od    = 8'h00;
                    d.ol    = 1'b0;
                    ctr_inc = 1'b1;
                    crc_adv = 1'b1;
                    if (cnt_next == CNT_W'(PAD_DATA)) begin
                        if (q.fcs_sel) begin
                            d.state = ST_FCS;
                            d.idx   = 2'd0;
                        end else begin
                            d.ol    = 1'b1;
                            d.state = ST_DATA;
                            ctr_clr = 1'b1;
                            crc_clr = 1'b1;
                        end
                    end
                end
            end
            ST_FCS: begin
                if (slot_free) begin
                    d.ov  = 1'b1;
                    d.od  = crc_out[8*q.idx +: 8];
                    d.ol  = (q.idx == 2'd3);
                    d.idx = q.idx + 2'd1;
                    if (q.idx == 2'd3) begin
                        d.state = ST_DATA;
                        ctr_clr = 1'b1;
                        crc_clr = 1'b1;
                    end
                end
            end
            ST_DROP: begin
                if (in_valid && in_eop) begin
                    d.state = ST_DATA;
                end
            end
            default: d.state = ST_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_DATA, ov: 1'b0, od: 8'h00, ol: 1'b0,
                   err: 1'b0, fcs_sel: 1'b0, idx: 2'd0};
        end else begin
            q <= d;
        end
    end

    assign out_valid    = q.ov;
    assign out_data     = q.od;
    assign out_last     = q.ol;
    assign err_oversize = q.err;
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
    parameter int MIN_TOTAL   = 64,
    parameter int MAX_TOTAL   = 1536,
    parameter int JUMBO_TOTAL = 9018
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_pad_en,
    input logic       cfg_jumbo_en,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       err_oversize
);
    localparam int PAD_DATA = MIN_TOTAL - 4;

    logic [15:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (out_valid && out_ready) begin
            beats_q <= out_last ? 16'd0 : beats_q + 16'd1;
        end
    end

    // R10: a stalled byte holds
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R7: the error is a single-cycle pulse
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_oversize |=> !err_oversize);

    // R7: the error comes with the final byte of the cut frame
    p_err_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_oversize |-> out_valid && out_last);

    // R8: no frame grows past the active total limit
    p_len_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |->
            (int'(beats_q) < (cfg_jumbo_en ? JUMBO_TOTAL : MAX_TOTAL)));

    // R5: padded frames reach the minimum data length
    p_pad_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last && cfg_pad_en |->
            (int'(beats_q) + 1 >= PAD_DATA));
endmodule

bind tx_frame_builder txf_checker #(
    .MIN_TOTAL   (MIN_TOTAL),
    .MAX_TOTAL   (MAX_TOTAL),
    .JUMBO_TOTAL (JUMBO_TOTAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_pad_en   (cfg_pad_en),
    .cfg_jumbo_en (cfg_jumbo_en),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last),
    .err_oversize (err_oversize)
);

// File: tb/tx_frame_builder_bench.sv
`timescale 1ns/1ps
module tx_frame_builder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pad_en = 1'b0;
    logic       cfg_jumbo_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_eop = 1'b0;
    logic       in_fcs = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_last;
    logic       err_oversize;

    always #2.5 clk = ~clk;

    tx_frame_builder u_tx_frame_builder (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_pad_en   (cfg_pad_en),
        .cfg_jumbo_en (cfg_jumbo_en),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_eop       (in_eop),
        .in_fcs       (in_fcs),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_last     (out_last),
        .err_oversize (err_oversize)
    );

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    int err_exp = 0;
    int ready_mode = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] exp_data[$];
    bit         exp_last[$];
    string      exp_tag[$];

    bit         prev_stall = 0;
    logic [7:0] prev_data = 8'h00;
    bit         prev_last = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Bench CRC: MSB-first register over bit-reversed input, reversed at the end.
    function automatic logic [31:0] ref_crc(input logic [7:0] bytes[$]);
        logic [31:0] c;
        logic [31:0] r;
        bit fb;
        c = 32'hFFFF_FFFF;
        foreach (bytes[i]) begin
            for (int j = 0; j < 8; j++) begin
                fb = c[31] ^ bytes[i][j];
                c  = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        for (int j = 0; j < 32; j++) r[j] = c[31-j];
        return ~r;
    endfunction

    task automatic expect_frame(input logic [7:0] fb[$], input bit fcs);
        int lim;
        logic [7:0] body[$];
        logic [31:0] c;
        lim = cfg_jumbo_en ? 9014 : 1532;
        if (fb.size() > lim) begin
            for (int i = 0; i < lim; i++) begin
                exp_data.push_back(fb[i]);
                exp_last.push_back(i == lim - 1);
                exp_tag.push_back("R7");
            end
            err_exp++;
            return;
        end
        body = fb;
        foreach (fb[i]) begin
            exp_data.push_back(fb[i]);
            exp_last.push_back(0);
            exp_tag.push_back("R2");
        end
        if (cfg_pad_en) begin
            while (body.size() < 60) begin
                body.push_back(8'h00);
                exp_data.push_back(8'h00);
                exp_last.push_back(0);
                exp_tag.push_back("R5");
            end
        end
        if (fcs) begin
            c = ref_crc(body);
            for (int k = 0; k < 4; k++) begin
                exp_data.push_back(c[8*k +: 8]);
                exp_last.push_back(0);
                exp_tag.push_back("R3");
            end
        end
        exp_last[exp_last.size()-1] = 1;
    endtask

    task automatic send_frame(input int n, input bit fcs, input bit noise,
                              input bit gaps, input int seed);
        logic [7:0] fb[$];
        for (int i = 0; i < n; i++) fb.push_back(8'(seed * 31 + i * 13 + (i >> 3)));
        expect_frame(fb, fcs);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gaps && (i % 5 == 2)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = fb[i];
            in_eop   = (i == n - 1);
            // R4: the flag is raised on non-final bytes when noise is set
            in_fcs   = (i == n - 1) ? fcs : noise;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
        in_fcs   = 1'b0;
    endtask

    task automatic drain();
        while (exp_data.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = 1'($urandom % 2);
        endcase
    end

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (err_oversize) err_seen++;
            if (prev_stall) begin
                chk(out_valid && out_data == prev_data && out_last == prev_last,
                    "R10", "stalled byte changed", {out_valid, out_data}, {1'b1, prev_data});
            end
            if (out_valid && out_ready) begin
                if (exp_data.size() == 0) begin
                    chk(0, "R10", "unexpected output byte", out_data, 0);
                end else begin
                    chk(out_data == exp_data[0], exp_tag[0], "data", out_data, exp_data[0]);
                    chk(out_last == exp_last[0], "R11", "last flag", out_last, exp_last[0]);
                    void'(exp_data.pop_front());
                    void'(exp_last.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=%0d expected=0", exp_data.size());
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(err_oversize == 1'b0, "R1", "err after reset", err_oversize, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid out of reset", out_valid, 0);

        // R5 R3: short frame padded to 64 with check sequence
        cfg_pad_en = 1'b1;
        send_frame(40, 1, 0, 0, 1);
        drain();
        // R2 R3: longer frame, periodic stall
        ready_mode = 1;
        send_frame(80, 1, 0, 0, 2);
        drain();
        // R6: no pad, no check sequence
        cfg_pad_en = 1'b0;
        send_frame(20, 0, 0, 0, 3);
        drain();
        // R4: flag only on non-final bytes
        send_frame(30, 0, 1, 0, 4);
        drain();
        // R5: pad without check sequence, then the pad boundary
        cfg_pad_en = 1'b1;
        send_frame(50, 0, 0, 0, 5);
        send_frame(59, 1, 0, 0, 6);
        send_frame(60, 1, 0, 0, 7);
        send_frame(61, 1, 1, 0, 8);
        drain();
        // R8: exactly at the limit
        ready_mode = 0;
        send_frame(1532, 1, 0, 0, 9);
        drain();
        chk(err_seen == 0, "R8", "error at exact limit", err_seen, 0);
        // R7: over the limit, then a normal frame
        send_frame(1600, 1, 0, 0, 10);
        send_frame(45, 1, 0, 0, 11);
        drain();
        chk(err_seen == 1, "R7", "error pulses after truncation", err_seen, 1);
        // R9: jumbo allows a longer frame
        cfg_jumbo_en = 1'b1;
        send_frame(2000, 1, 0, 0, 12);
        drain();
        chk(err_seen == 1, "R9", "error with jumbo enabled", err_seen, 1);
        cfg_jumbo_en = 1'b0;
        // R10: random stall with input gaps
        ready_mode = 2;
        for (int f = 0; f < 6; f++) begin
            send_frame(14 + f * 17, f % 2, f % 3 == 0, 1, 20 + f);
        end
        drain();
        ready_mode = 0;
        chk(exp_data.size() == 0, "R10", "bytes still expected", exp_data.size(), 0);
        chk(err_seen == err_exp, "R7", "total error pulses", err_seen, err_exp);
        finish_run();
    end
endmodule